// File: doc/BRIEF.md
# Register-Controlled 8-Bit PWM Generator

This block produces one pulse-width-modulated output from a single 32-bit control word. Software writes the word through a simple write port with byte-lane strobes and reads it back at any time. A run bit starts and stops the waveform, and an idle-level bit sets the pin while the waveform is stopped. Two 8-bit fields set the waveform: a reload value that divides the input clock, and a duty value.

The divided clock steps an 8-bit phase counter, so one output period is 256 divided ticks. The duty value gives how many of those 256 positions are spent low at the start of each period. The pin is high for the rest. New reload and duty values are taken only when the phase counter wraps, so a period is never cut short or stretched by a write. The run bit reaches the counters one clock after the write, so every run starts from phase zero.

Top module: `pwm_ctrl8`

## Requirements
- R1: After reset the control word reads 0x0000_0000 and `pwm_out` is 0.
- R2: While the channel is stopped, `pwm_out` equals control bit 30 (idle level).
- R3: A write with all four strobes set makes `rd_data` equal the written word from the next cycle on, all 32 bits included.
- R4: Each strobe bit i enables byte lane i (bits 8i+7:8i). A write to lanes 0 and 1 alone leaves bits 31:16, including the run and idle bits, unchanged.
- R5: The reload field is bits 15:8. A value R from 1 to 255 advances the phase counter once every R input clocks, so the period is 256*R clocks.
- R6: A reload field of 0 advances the phase counter once every 256 input clocks.
- R7: The duty field is bits 7:0. While running, `pwm_out` is 0 when the phase is below D and 1 when the phase is from D up to 255.
- R8: With D = 0, `pwm_out` stays 1 for the whole period.
- R9: Control bit 31 is the run bit. After the write that sets it, the next clock starts the prescaler and the phase at zero, with the reload and duty then in the word. The output in cycle k after that clock follows R5 to R7 with phase floor(k/divisor) mod 256.
- R10: After the write that clears bit 31, one clock later the output returns to the idle level and both counters are held at zero.
- R11: Reload and duty writes made while running take effect only at the next wrap of the phase from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | PWM output pin |

## Verification
The bench checks whole periods cycle by cycle against an arithmetic model for several reload and duty pairs. These include the duty extremes 0, 1 and 255, where an off-by-one compare would give a stray low cycle or a missing high cycle. For the reload value 0, the bench checks that the phase steps after exactly 256 clocks. A design that divides by 0 or by 1 there would step the phase at the wrong clock. The bench writes a new duty in the middle of a period and expects the old duty until the wrap, so a design that takes the value at once shows a shortened pulse. It also writes the lower half of the word alone, which catches a design that clobbers the run and idle bits. Stopping and restarting must bring back the idle level and a restart from phase zero; a counter that is not cleared would show up as a shifted waveform.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int REG_W    = 32;
  localparam int LANES    = REG_W / 8;
  localparam int FIELD_W  = 8;
  localparam int RUN_BIT  = 31;
  localparam int IDLE_BIT = 30;
  localparam int DIV_LSB  = 8;
  localparam int DUTY_LSB = 0;

  // Last prescaler count before a tick; reload 0 wraps to the all-ones terminal (divide by 256).
  function automatic logic [FIELD_W-1:0] div_terminal(input logic [FIELD_W-1:0] reload);
    return reload - 1'b1;
  endfunction

  // Output level for a given phase: low below the duty threshold, high from it on.
  function automatic logic phase_level(input logic [FIELD_W-1:0] phase,
                                       input logic [FIELD_W-1:0] duty);
    return phase >= duty;
  endfunction
endpackage

// File: rtl/pwm8_ctrl_reg.sv
module pwm8_ctrl_reg
  import pwm8_pkg::*;
#(
  parameter int W = REG_W,
  localparam int NL = W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NL-1:0] wr_be,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  word_q
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[8*g +: 8] <= '0;
      else if (wr_en && wr_be[g])
        word_q[8*g +: 8] <= wr_data[8*g +: 8];
    end
  end
endmodule

// File: rtl/pwm8_prescale.sv
module pwm8_prescale
  import pwm8_pkg::*;
#(
  parameter int CW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] terminal,
  output logic [CW-1:0] cnt_q,
  output logic          tick
);
  assign tick = run && (cnt_q == terminal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm8_phase_gen.sv
module pwm8_phase_gen
  import pwm8_pkg::*;
#(
  parameter int PW = FIELD_W,
  localparam logic [PW-1:0] PH_LAST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [PW-1:0] reload_in,
  input  logic [PW-1:0] duty_in,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] reload_sh,
  output logic [PW-1:0] duty_sh,
  output logic          wrap,
  output logic          level
);
  assign wrap  = tick && (phase_q == PH_LAST);
  assign level = phase_level(phase_q, duty_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (!run)   phase_q <= '0;
    else if (tick)   phase_q <= phase_q + 1'b1;
  end

  // Shadow copies follow the word while stopped and refresh only at a wrap while running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_sh <= '0;
      duty_sh   <= '0;
    end else if (!run || wrap) begin
      reload_sh <= reload_in;
      duty_sh   <= duty_in;
    end
  end
endmodule

// File: rtl/pwm_ctrl8.sv
module pwm_ctrl8
  import pwm8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             pwm_out
);
  logic [REG_W-1:0]   word_q;
  logic               run_q;
  logic               tick;
  logic               wrap;
  logic               level;
  logic [FIELD_W-1:0] pre_cnt;
  logic [FIELD_W-1:0] phase_q;
  logic [FIELD_W-1:0] reload_sh;
  logic [FIELD_W-1:0] duty_sh;
  logic [FIELD_W-1:0] term;

  pwm8_ctrl_reg #(.W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .word_q(word_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= word_q[RUN_BIT];
  end

  assign term = div_terminal(reload_sh);

  pwm8_prescale #(.CW(FIELD_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .terminal(term),
    .cnt_q(pre_cnt), .tick(tick)
  );

  pwm8_phase_gen #(.PW(FIELD_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick),
    .reload_in(word_q[DIV_LSB +: FIELD_W]),
    .duty_in(word_q[DUTY_LSB +: FIELD_W]),
    .phase_q(phase_q), .reload_sh(reload_sh), .duty_sh(duty_sh),
    .wrap(wrap), .level(level)
  );

  assign rd_data = word_q;
  assign pwm_out = run_q ? level : word_q[IDLE_BIT];
endmodule

// File: rtl/pwm8_chk.sv
module pwm8_chk
  import pwm8_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [LANES-1:0]   wr_be,
  input logic [REG_W-1:0]   wr_data,
  input logic [REG_W-1:0]   rd_data,
  input logic               pwm_out,
  input logic               run_q,
  input logic               tick,
  input logic               wrap,
  input logic [FIELD_W-1:0] pre_cnt,
  input logic [FIELD_W-1:0] phase_q,
  input logic [FIELD_W-1:0] duty_sh,
  input logic [FIELD_W-1:0] reload_sh,
  input logic [FIELD_W-1:0] term
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> pwm_out == rd_data[IDLE_BIT]); // R2
  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == '1) |=> rd_data == $past(wr_data)); // R3
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[LANES-1] == 1'b0) |=> rd_data[RUN_BIT] == $past(rd_data[RUN_BIT])); // R4
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> pre_cnt <= term); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> $stable(phase_q)); // R5
  AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && duty_sh == '0) |-> pwm_out); // R8
  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (phase_q == '0 && pre_cnt == '0)); // R10
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap) |=> ($stable(duty_sh) && $stable(reload_sh))); // R11
endmodule

bind pwm_ctrl8 pwm8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
  .rd_data(rd_data), .pwm_out(pwm_out), .run_q(run_q), .tick(tick), .wrap(wrap),
  .pre_cnt(pre_cnt), .phase_q(phase_q), .duty_sh(duty_sh), .reload_sh(reload_sh),
  .term(term)
);

// File: tb/pwm_ctrl8_tb.sv
module pwm_ctrl8_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  pwm_ctrl8 u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_level(int k, int reload, int duty);
    int div = (reload == 0) ? 256 : reload;
    int ph  = (k / div) % 256;
    return ph >= duty;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Drives one write on a falling edge; returns on the falling edge after the capturing rise.
  task automatic write(logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  // Starts a run and compares n cycles against the model, from k = 0.
  task automatic run_sweep(string req, int reload, int duty, int n);
    write({2'b10, 14'd0, reload[7:0], duty[7:0]}, 4'hF);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(req, {31'd0, pwm_out}, {31'd0, model_level(k, reload, duty)});
    end
  endtask

  task automatic stop();
    write(32'h0, 4'hF);
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", rd_data, 32'h0);
    check("R1 reset pin", {31'd0, pwm_out}, 32'h0);

    // R2: idle level follows bit 30 while stopped
    write(32'h4000_0000, 4'hF);
    check("R2 idle high", {31'd0, pwm_out}, 32'h1);
    write(32'h0000_0000, 4'hF);
    check("R2 idle low", {31'd0, pwm_out}, 32'h0);

    // R3: full readback
    write(32'h5ABC_1234, 4'hF);
    check("R3 readback", rd_data, 32'h5ABC_1234);
    check("R2 idle after readback write", {31'd0, pwm_out}, 32'h1);

    // R4: lower-lane write keeps upper bits
    write(32'hFFFF_FFFF, 4'h3);
    check("R4 lanes 0-1 only", rd_data, 32'h5ABC_FFFF);
    write(32'h0000_0000, 4'h4);
    check("R4 lane 2 only", rd_data, 32'h5A00_FFFF);
    stop();

    // R5 / R7 / R8 / R9: full-period sweeps
    run_sweep("R7 div1 duty1", 1, 1, 256);     stop();
    run_sweep("R7 div1 duty128", 1, 128, 256); stop();
    run_sweep("R7 div1 duty255", 1, 255, 256); stop();
    run_sweep("R8 div1 duty0", 1, 0, 300);     stop();
    run_sweep("R5 div3 duty100", 3, 100, 800); stop();
    run_sweep("R5 div2 duty7", 2, 7, 520);     stop();

    // R6: reload 0 divides by 256; phase steps after exactly 256 clocks
    run_sweep("R6 div256 duty1", 0, 1, 260);   stop();

    // R10: stop returns idle level, restart from phase zero
    run_sweep("R9 start", 4, 50, 300);
    write(32'h4000_0000, 4'hF);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R10 idle after stop", {31'd0, pwm_out}, 32'h1);
    end
    run_sweep("R10 restart from zero", 4, 50, 260);
    stop();

    // R11: duty change mid-period waits for the wrap
    write({2'b10, 14'd0, 8'd1, 8'd64}, 4'hF);
    for (int k = 0; k < 520; k++) begin
      @(negedge clk);
      check("R11 deferred duty", {31'd0, pwm_out},
            {31'd0, model_level(k, 1, (k < 256) ? 64 : 200)});
      if (k == 100) begin
        wr_en = 1'b1; wr_be = 4'h1; wr_data = 32'h0000_00C8;
      end else begin
        wr_en = 1'b0; wr_be = '0;
      end
    end
    check("R4 run bit kept by duty write", {31'd0, rd_data[31]}, 32'h1);
    stop();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule